// File: doc/BRIEF.md
# Interface Bring-Up Sequencing Controller

This block decides when a peripheral data interface may talk. It watches a power request, a power-good flag from each of two voltage domains, a connector presence flag, a bus-idle flag and the reply of a small identity probe. From these it drives the enable of the level translator between the domains, an active-low reset into the peripheral, a one-cycle strobe that starts the probe, a grant that opens full traffic, and a flag that marks the feature unavailable.

Every step waits for a hardware condition, not for time alone. Rail and presence flags must first hold high for a set number of cycles. The domains stay isolated with the peripheral in reset until that is done. Then isolation opens, reset is released, and the block waits for an idle bus. Only the identity probe runs first. Full traffic follows only when the probe succeeds. A failed or silent probe leads to a reset-and-retry cycle. Once the retries are spent, the interface stays isolated and is marked unavailable. Losing a rail or presence isolates the interface at once. Dropping the power request closes it down in reverse order.

Top module: `ifc_bringup_ctrl`

## Requirements
- R1: During reset and right after it, `xlat_oe_o`=0, `periph_rst_no`=0, `grant_o`=0, `probe_start_o`=0 and `unavail_o`=0.
- R2: Bring-up runs in this order, with each step on a later cycle than the one before: request seen, rails and presence qualified, reset held with isolation kept, `xlat_oe_o` raised while reset stays asserted, `periph_rst_no` released, bus idle seen, probe strobe, grant. `periph_rst_no` never rises while `xlat_oe_o` is low, and `xlat_oe_o` never falls while `periph_rst_no` is high.
- R3: `xlat_oe_o` is high in a cycle only if both rail-good inputs were high in the cycle before.
- R4: A rail-good or presence input counts as valid only after it has been high for `STABLE_CYC` (default 16) consecutive rising edges. With the request already up, `xlat_oe_o` rises exactly `STABLE_CYC`+2 cycles after the last of these inputs goes high.
- R5: `probe_start_o` pulses only in the cycle after one in which `bus_idle_i` and `present_i` were both high. With presence low, the interface stays isolated.
- R6: The first activity after reset release is a one-cycle `probe_start_o`. `grant_o` rises only in the cycle after `probe_done_i`=1 with `probe_ok_i`=1.
- R7: A probe failure is `probe_done_i`=1 with `probe_ok_i`=0, or a timeout. After a failure, while fewer than `MAX_RETRY` (default 3) retries have been used, `periph_rst_no` is driven low for exactly `RST_HOLD_CYC` (default 8) cycles with `xlat_oe_o` kept high, and the block then waits for idle again. The next failure drives `xlat_oe_o`, `periph_rst_no` and `grant_o` low and `unavail_o` high, all in the same cycle. These outputs stay that way until the request drops.
- R8: If either rail-good input or presence was low in a cycle, then in the next cycle `xlat_oe_o`, `periph_rst_no` and `grant_o` are all low. Bring-up restarts by itself once the inputs qualify again.
- R9: When `pwr_req_i` falls in an active state, `grant_o` falls one cycle later, `periph_rst_no` falls the cycle after that, and `xlat_oe_o` falls one cycle after that.
- R10: The wait for bus idle and the wait for the probe reply each last at most `TMO_CYC` (default 1024) cycles. At expiry the block takes the failure path of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Power/bring-up request |
| rail_a_good_i | input | 1 | Power-good of domain A |
| rail_b_good_i | input | 1 | Power-good of domain B |
| present_i | input | 1 | Connector presence detect |
| bus_idle_i | input | 1 | Bus reads idle |
| probe_done_i | input | 1 | Identity probe finished (one cycle) |
| probe_ok_i | input | 1 | Probe result, valid with probe_done_i |
| xlat_oe_o | output | 1 | Level translator output enable |
| periph_rst_no | output | 1 | Peripheral reset, active low |
| probe_start_o | output | 1 | One-cycle strobe that starts the identity probe |
| grant_o | output | 1 | Full communication granted |
| unavail_o | output | 1 | Feature marked unavailable |

## Verification
On every cycle, the assertions check these safety relations:
- the enable follows the rails in the cycle before;
- any loss of rail or presence isolates the interface in the next cycle;
- reset is released only with the enable high, and the enable drops only with reset asserted;
- the probe strobe follows an idle bus with presence;
- grant rises only after a successful probe reply;
- the unavailable flag goes with full isolation.

Some behaviour is shown only by the bench's scenarios:
- the exact qualification delay;
- the order of output changes across a whole bring-up;
- the eight-cycle retry reset;
- the two timeout lengths;
- the retry limit;
- the one-cycle spacing of the shutdown.

// File: rtl/ifc_bringup_pkg.sv
package ifc_bringup_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_RAILS,
    ST_HOLD,
    ST_ISO,
    ST_IDLE_WAIT,
    ST_PROBE_GO,
    ST_PROBE_WAIT,
    ST_GRANT,
    ST_RETRY,
    ST_FAIL,
    ST_SD_GRANT,
    ST_SD_RST
  } bu_state_e;

  typedef struct packed {
    logic oe;
    logic rst_n;
    logic start;
    logic grant;
    logic unavail;
  } bu_out_t;

endpackage

// File: rtl/ifc_qualify.sv
// Input is valid only after STABLE_CYC consecutive high samples; drops at once.
module ifc_qualify #(
  parameter int STABLE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic valid_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(STABLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!raw_i)       cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = raw_i && (cnt_q == FULL);
endmodule

// File: rtl/ifc_stage_timer.sv
// Counts cycles spent in the current state; saturates.
module ifc_stage_timer #(
  parameter int TW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (clr_i)       cnt_o <= '0;
    else if (~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ifc_bringup_fsm.sv
module ifc_bringup_fsm
  import ifc_bringup_pkg::*;
#(
  parameter int TMO_CYC      = 1024,
  parameter int RST_HOLD_CYC = 8,
  parameter int MAX_RETRY    = 3,
  parameter int TW           = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_req_i,
  input  logic          env_ok_i,
  input  logic          bus_idle_i,
  input  logic          probe_done_i,
  input  logic          probe_ok_i,
  input  logic [TW-1:0] tcnt_i,
  output logic          tclr_o,
  output bu_out_t       out_o
);
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(RST_HOLD_CYC - 1);
  localparam logic [RW-1:0] RETRY_MAX = RW'(MAX_RETRY);

  bu_state_e state_q, state_d;
  logic [RW-1:0] retry_q, retry_d;
  logic live, powered, fail;

  // states that hold any part of the interface open
  assign live = state_q inside {ST_HOLD, ST_ISO, ST_IDLE_WAIT, ST_PROBE_GO,
                                ST_PROBE_WAIT, ST_GRANT, ST_RETRY,
                                ST_SD_GRANT, ST_SD_RST};
  assign powered = state_q inside {ST_ISO, ST_IDLE_WAIT, ST_PROBE_GO,
                                   ST_PROBE_WAIT, ST_GRANT, ST_RETRY};

  always_comb begin
    fail = 1'b0;
    if (state_q == ST_IDLE_WAIT && !bus_idle_i && tcnt_i == TMO_LAST) fail = 1'b1;
    if (state_q == ST_PROBE_WAIT &&
        ((probe_done_i && !probe_ok_i) || (!probe_done_i && tcnt_i == TMO_LAST)))
      fail = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    retry_d = retry_q;
    if (live && !env_ok_i) begin
      state_d = ST_RAILS;
    end else if (powered && !pwr_req_i) begin
      state_d = ST_SD_GRANT;
    end else if (fail) begin
      if (retry_q < RETRY_MAX) begin
        state_d = ST_RETRY;
        retry_d = retry_q + 1'b1;
      end else begin
        state_d = ST_FAIL;
      end
    end else begin
      unique case (state_q)
        ST_OFF:        if (pwr_req_i) state_d = ST_RAILS;
        ST_RAILS: begin
          retry_d = '0;
          if (!pwr_req_i)    state_d = ST_OFF;
          else if (env_ok_i) state_d = ST_HOLD;
        end
        ST_HOLD:       state_d = pwr_req_i ? ST_ISO : ST_OFF;
        ST_ISO:        state_d = ST_IDLE_WAIT;
        ST_IDLE_WAIT:  if (bus_idle_i) state_d = ST_PROBE_GO;
        ST_PROBE_GO:   state_d = ST_PROBE_WAIT;
        ST_PROBE_WAIT: if (probe_done_i && probe_ok_i) state_d = ST_GRANT;
        ST_GRANT:      ;
        ST_RETRY:      if (tcnt_i == HOLD_LAST) state_d = ST_IDLE_WAIT;
        ST_FAIL:       if (!pwr_req_i) state_d = ST_OFF;
        ST_SD_GRANT:   state_d = ST_SD_RST;
        ST_SD_RST:     state_d = ST_OFF;
        default:       state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
    end
  end

  assign tclr_o = (state_d != state_q);

  always_comb begin
    out_o = '0;
    unique case (state_q)
      ST_ISO, ST_RETRY, ST_SD_RST:          out_o.oe = 1'b1;
      ST_IDLE_WAIT, ST_PROBE_WAIT, ST_SD_GRANT: begin
        out_o.oe    = 1'b1;
        out_o.rst_n = 1'b1;
      end
      ST_PROBE_GO: begin
        out_o.oe    = 1'b1;
        out_o.rst_n = 1'b1;
        out_o.start = 1'b1;
      end
      ST_GRANT: begin
        out_o.oe    = 1'b1;
        out_o.rst_n = 1'b1;
        out_o.grant = 1'b1;
      end
      ST_FAIL: out_o.unavail = 1'b1;
      default: out_o = '0;
    endcase
  end
endmodule

// File: rtl/ifc_bringup_ctrl.sv
module ifc_bringup_ctrl
  import ifc_bringup_pkg::*;
#(
  parameter int STABLE_CYC   = 16,
  parameter int TMO_CYC      = 1024,
  parameter int RST_HOLD_CYC = 8,
  parameter int MAX_RETRY    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_req_i,
  input  logic rail_a_good_i,
  input  logic rail_b_good_i,
  input  logic present_i,
  input  logic bus_idle_i,
  input  logic probe_done_i,
  input  logic probe_ok_i,
  output logic xlat_oe_o,
  output logic periph_rst_no,
  output logic probe_start_o,
  output logic grant_o,
  output logic unavail_o
);
  localparam int NQ   = 3;
  localparam int TMAX = (TMO_CYC > RST_HOLD_CYC) ? TMO_CYC : RST_HOLD_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic [NQ-1:0] raw, qual;
  logic [TW-1:0] tcnt;
  logic          tclr;
  bu_out_t       outs;

  assign raw = {present_i, rail_b_good_i, rail_a_good_i};

  for (genvar g = 0; g < NQ; g++) begin : g_qual
    ifc_qualify #(.STABLE_CYC(STABLE_CYC)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .valid_o(qual[g])
    );
  end

  ifc_stage_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tclr),
    .cnt_o (tcnt)
  );

  ifc_bringup_fsm #(
    .TMO_CYC     (TMO_CYC),
    .RST_HOLD_CYC(RST_HOLD_CYC),
    .MAX_RETRY   (MAX_RETRY),
    .TW          (TW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_req_i   (pwr_req_i),
    .env_ok_i    (&qual),
    .bus_idle_i  (bus_idle_i),
    .probe_done_i(probe_done_i),
    .probe_ok_i  (probe_ok_i),
    .tcnt_i      (tcnt),
    .tclr_o      (tclr),
    .out_o       (outs)
  );

  assign xlat_oe_o     = outs.oe;
  assign periph_rst_no = outs.rst_n;
  assign probe_start_o = outs.start;
  assign grant_o       = outs.grant;
  assign unavail_o     = outs.unavail;
endmodule

// File: rtl/ifc_bringup_chk.sv
module ifc_bringup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rail_a_good_i,
  input logic rail_b_good_i,
  input logic present_i,
  input logic bus_idle_i,
  input logic probe_done_i,
  input logic probe_ok_i,
  input logic xlat_oe_o,
  input logic periph_rst_no,
  input logic probe_start_o,
  input logic grant_o,
  input logic unavail_o
);
  assert_oe_rails_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_oe_o |-> $past(rail_a_good_i && rail_b_good_i));

  assert_loss_isolates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rail_a_good_i && rail_b_good_i && present_i)
      |-> (!xlat_oe_o && !periph_rst_no && !grant_o));

  assert_rst_release_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(periph_rst_no) |-> xlat_oe_o);

  assert_oe_drop_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xlat_oe_o) |-> !periph_rst_no);

  assert_probe_needs_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_start_o |-> $past(bus_idle_i && present_i));

  assert_grant_after_probe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(probe_done_i && probe_ok_i));

  assert_unavail_isolated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o |-> (!xlat_oe_o && !periph_rst_no && !grant_o && !probe_start_o));
endmodule

bind ifc_bringup_ctrl ifc_bringup_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rail_a_good_i(rail_a_good_i),
  .rail_b_good_i(rail_b_good_i),
  .present_i    (present_i),
  .bus_idle_i   (bus_idle_i),
  .probe_done_i (probe_done_i),
  .probe_ok_i   (probe_ok_i),
  .xlat_oe_o    (xlat_oe_o),
  .periph_rst_no(periph_rst_no),
  .probe_start_o(probe_start_o),
  .grant_o      (grant_o),
  .unavail_o    (unavail_o)
);

// File: tb/ifc_bringup_ctrl_tb_top.sv
`timescale 1ns/1ps
module ifc_bringup_ctrl_tb_top;
  localparam int STABLE = 16;
  localparam int TMO    = 1024;
  localparam int HOLD   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_req = 0, rail_a = 0, rail_b = 0, present = 0, bus_idle = 0;
  logic probe_done = 0, probe_ok = 0;
  logic oe, prst_n, pstart, grant, unavail;

  always #2 clk = ~clk;  // 250 MHz

  ifc_bringup_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_req_i(pwr_req),
    .rail_a_good_i(rail_a), .rail_b_good_i(rail_b), .present_i(present),
    .bus_idle_i(bus_idle), .probe_done_i(probe_done), .probe_ok_i(probe_ok),
    .xlat_oe_o(oe), .periph_rst_no(prst_n), .probe_start_o(pstart),
    .grant_o(grant), .unavail_o(unavail)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit mon_en = 0, done = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  int         plan_q[$];   // 0 ok, 1 fail, 2 silent
  int         ev_t[0:255];
  int         ev_n = 0;
  logic [4:0] prev = 5'b00000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_ev(input logic [4:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: every change of {oe,rst_n,start,grant,unavail} pops one expected item
  always @(negedge clk) begin
    logic [4:0] cur;
    cur = {oe, prst_n, pstart, grant, unavail};
    if (mon_en && cur !== prev) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected output change: actual=%b expected=none", cur);
      end else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cur !== e) begin
          errors++;
          $display("FAIL %s output sequence: actual=%b expected=%b", t, cur, e);
        end
      end
      if (ev_n < 256) ev_t[ev_n] = cyc;
      ev_n++;
      prev = cur;
    end
  end

  // probe responder
  initial begin
    forever begin
      @(negedge clk);
      if (pstart) begin
        int mode;
        mode = (plan_q.size() != 0) ? plan_q.pop_front() : 2;
        if (mode != 2) begin
          repeat (5) @(negedge clk);
          probe_done = 1'b1;
          probe_ok   = (mode == 0);
          @(negedge clk);
          probe_done = 1'b0;
          probe_ok   = 1'b0;
        end
      end
    end
  end

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic push_bringup_ok();
    push_ev(5'b10000, "R2");
    push_ev(5'b11000, "R2");
    push_ev(5'b11100, "R6");
    push_ev(5'b11000, "R6");
    push_ev(5'b11010, "R6");
    plan_q.push_back(0);
  endtask

  initial begin
    int t0, n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(oe == 0 && prst_n == 0 && grant == 0 && pstart == 0 && unavail == 0,
        "R1 reset outputs", {oe, prst_n, grant, unavail}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({oe, prst_n, grant, unavail} == 0, "R1 after release", {oe, prst_n, grant, unavail}, 0);
    mon_en = 1;

    // R5: presence missing keeps interface isolated
    pwr_req = 1; rail_a = 1; rail_b = 1;
    repeat (60) @(negedge clk);
    chk(oe == 0 && prst_n == 0, "R5 no presence isolated", oe, 0);

    // R4/R2/R6: bring-up with bus busy at first
    push_bringup_ok();
    n0 = ev_n; t0 = cyc;
    present = 1;
    while (ev_n < n0 + 2) @(negedge clk);
    chk(ev_t[n0] - t0 == STABLE + 2, "R4 qualification delay", ev_t[n0] - t0, STABLE + 2);
    chk(ev_t[n0 + 1] - ev_t[n0] == 1, "R2 reset release after enable", ev_t[n0 + 1] - ev_t[n0], 1);
    repeat (40) @(negedge clk);
    chk(pstart == 0 && oe == 1, "R5 no probe while bus busy", pstart, 0);
    t0 = cyc;
    bus_idle = 1;
    drain("R6 bring-up sequence");
    chk(ev_t[n0 + 2] - t0 == 1, "R5 probe after idle", ev_t[n0 + 2] - t0, 1);
    chk(grant == 1, "R6 grant after probe ok", grant, 1);

    // R9 orderly shutdown
    push_ev(5'b11000, "R9");
    push_ev(5'b10000, "R9");
    push_ev(5'b00000, "R9");
    n0 = ev_n; t0 = cyc;
    pwr_req = 0;
    drain("R9 shutdown sequence");
    chk(ev_t[n0] - t0 == 1, "R9 grant off", ev_t[n0] - t0, 1);
    chk(ev_t[n0 + 1] - ev_t[n0] == 1, "R9 reset after grant", ev_t[n0 + 1] - ev_t[n0], 1);
    chk(ev_t[n0 + 2] - ev_t[n0 + 1] == 1, "R9 enable off last", ev_t[n0 + 2] - ev_t[n0 + 1], 1);

    // R7 one failed probe, then retry succeeds
    push_ev(5'b10000, "R2");
    push_ev(5'b11000, "R2");
    push_ev(5'b11100, "R6");
    push_ev(5'b11000, "R6");
    push_ev(5'b10000, "R7");
    push_ev(5'b11000, "R7");
    push_ev(5'b11100, "R7");
    push_ev(5'b11000, "R7");
    push_ev(5'b11010, "R7");
    plan_q.push_back(1);
    plan_q.push_back(0);
    n0 = ev_n;
    pwr_req = 1;
    drain("R7 retry sequence");
    chk(ev_t[n0 + 5] - ev_t[n0 + 4] == HOLD, "R7 retry reset width",
        ev_t[n0 + 5] - ev_t[n0 + 4], HOLD);
    chk(grant == 1, "R7 grant after retry", grant, 1);

    // R8 rail loss while granted
    push_ev(5'b00000, "R8");
    n0 = ev_n; t0 = cyc;
    rail_b = 0;
    drain("R8 rail loss");
    chk(ev_t[n0] - t0 == 1, "R8 isolate next cycle", ev_t[n0] - t0, 1);
    chk(oe == 0, "R3 enable off without rail", oe, 0);
    push_bringup_ok();
    rail_b = 1;
    drain("R8 recovery bring-up");

    // R8 presence loss, then R10/R7 timeouts to unavailable
    push_ev(5'b00000, "R8");
    present = 0;
    drain("R8 presence loss");
    bus_idle = 0;
    push_ev(5'b10000, "R2");
    push_ev(5'b11000, "R2");
    push_ev(5'b10000, "R10");
    push_ev(5'b11000, "R10");
    push_ev(5'b11100, "R10");
    push_ev(5'b11000, "R10");
    push_ev(5'b10000, "R10");
    push_ev(5'b11000, "R7");
    push_ev(5'b11100, "R7");
    push_ev(5'b11000, "R7");
    push_ev(5'b10000, "R7");
    push_ev(5'b11000, "R7");
    push_ev(5'b11100, "R7");
    push_ev(5'b11000, "R7");
    push_ev(5'b00001, "R7");
    plan_q.delete();
    n0 = ev_n;
    present = 1;
    while (ev_n < n0 + 3) @(negedge clk);
    bus_idle = 1;
    drain("R10 timeout sequence");
    chk(ev_t[n0 + 2] - ev_t[n0 + 1] == TMO, "R10 idle timeout",
        ev_t[n0 + 2] - ev_t[n0 + 1], TMO);
    chk(ev_t[n0 + 6] - ev_t[n0 + 5] == TMO, "R10 probe timeout",
        ev_t[n0 + 6] - ev_t[n0 + 5], TMO);
    chk(ev_t[n0 + 14] - ev_t[n0 + 13] == TMO, "R7 last timeout to unavailable",
        ev_t[n0 + 14] - ev_t[n0 + 13], TMO);
    repeat (30) @(negedge clk);
    chk(unavail == 1 && oe == 0 && prst_n == 0, "R7 stays unavailable", unavail, 1);

    push_ev(5'b00000, "R7");
    pwr_req = 0;
    drain("R7 unavailable cleared");
    chk(unavail == 0, "R7 flag cleared on request drop", unavail, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule